// File: doc/BRIEF.md
# Microcoded Local-Bus Cycle Sequencer

This block generates the strobes for one external device on a local bus: a chip select, a write enable and an output enable. It has no fixed timing. Each bus cycle is played out from a 64-word pattern store of 32-bit microwords. A word gives the strobe levels at sub-clock resolution, how many clocks to hold them, whether the word belongs to a repeated loop body, whether an external wait line may stall it, whether it raises transfer-acknowledge, and whether it ends the pattern.

A host programs the store through two registers on a simple register port. The first is a mode register that holds an operation code, two loop counts and a store address. The second is a data register. With the operation set to load or fetch, each request on the device port moves one word between the data register and the store at the current address, and the address then steps by one. The host can poll the address to see that the transfer is complete. With the operation set to normal, a read request plays the pattern at word 0 and a write request plays the pattern at word 24. With the operation set to run, the pattern starts at the address field.

When a pattern finishes, the strobes return to their negated idle levels and a one-clock done pulse is raised. For reads, the external data bus is captured on the final clock of the pattern.

Top module: `lbus_microseq`

## Requirements
- R1: After reset all strobe outputs are negated (cs_q_n=4'hF, we_q_n=4'hF, oe_h_n=2'b11), ta and done are 0, rd_data is 0, and both registers read back 0.
- R2: reg_sel=0 selects the mode register and reg_sel=1 selects the data register. The mode register holds the operation at bits 29:28 (00 normal, 01 load store, 10 fetch store, 11 run), the read loop count at bits 17:14, the write loop count at bits 13:10 and the store address at bits 5:0. All other mode bits read 0.
- R3: In load mode, a dev_req cycle writes the data register into store[address], and the address then increments by one, wrapping from 63 to 0.
- R4: In fetch mode, a dev_req cycle copies store[address] into the data register, and the address then increments by one, wrapping from 63 to 0.
- R5: After reset every store word holds the idle filler 32'hFF03_0001, which has all strobes negated and the end flag set.
- R6: In normal mode, an idle dev_req starts a pattern at word 0 when dev_we=0 and at word 24 when dev_we=1. From the next clock, the outputs show the current word's fields: cs_q_n=w[31:28], we_q_n=w[27:24], oe_h_n=w[17:16] and ta=w[2]. Bit 0 of each output vector is the latest sub-phase of the clock.
- R7: A word stays on the outputs for w[9:8]+1 clocks.
- R8: Once the final clock of a word with w[0]=1 has passed, the strobes are idle and done is high for exactly one clock. A read pattern captures ext_din on that final clock into rd_data. A write pattern leaves rd_data unchanged.
- R9: While w[12]=1 and ext_wait=1, the current word is held, and its hold clocks are not counted.
- R10: Words with w[7]=1 form the loop body, which runs from the first such word to the last such word in a contiguous run. The body is played N times in total. N is the read loop count for reads and the write loop count for writes, and a count of 0 means 16.
- R11: In run mode, a pattern starts at the store address field, and the address field is not changed.
- R12: A dev_req that arrives while a pattern is playing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mode, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| dev_req | input | 1 | Device-region access request |
| dev_we | input | 1 | Request direction: 1 write, 0 read |
| ext_wait | input | 1 | External wait, honoured on wait-enabled words |
| ext_din | input | DATA_W | External data bus |
| cs_q_n | output | 4 | Chip-select level per quarter clock |
| we_q_n | output | 4 | Write-enable level per quarter clock |
| oe_h_n | output | 2 | Output-enable level per half clock |
| ta | output | 1 | Transfer acknowledge |
| done | output | 1 | One-clock pulse when a pattern ends |
| rd_data | output | DATA_W | Data captured at the end of a read |

## Verification
The checker checks the following on every clock. Strobes are negated whenever no pattern is playing. Done lasts a single clock and only while idle. A load-mode request advances the address by exactly one. A wait on a wait-enabled word freezes both the word pointer and its hold count. Run mode never moves the address. Other behaviours need the bench's scenarios to show them: the word order, the hold lengths, the loop-count arithmetic including the count of 0 meaning 16, the start offsets for each direction, the reset filler contents, and the clock on which read data is captured. The bench shows these by sweeping the whole store and every loop count, and by comparing pattern lengths and traces against arithmetic expectations.

// File: rtl/lbseq_pkg.sv
// Shared types and field positions for the microcoded bus sequencer.
// Assumes 32-bit microwords; field positions are fixed by the encoding.
package lbseq_pkg;

    localparam int WORD_W = 32;

    // Mode register operation codes
    typedef enum logic [1:0] {
        OP_NORMAL = 2'b00,
        OP_LOAD   = 2'b01,
        OP_FETCH  = 2'b10,
        OP_RUN    = 2'b11
    } op_e;

    // Mode register field positions
    localparam int MODE_OP_LSB = 28;
    localparam int MODE_RL_LSB = 14;
    localparam int MODE_WL_LSB = 10;
    localparam int MODE_AD_LSB = 0;

    // Microword field positions
    localparam int MW_CS_LSB   = 28;
    localparam int MW_WE_LSB   = 24;
    localparam int MW_OE_LSB   = 16;
    localparam int MW_WAEN_BIT = 12;
    localparam int MW_REP_LSB  = 8;
    localparam int MW_LOOP_BIT = 7;
    localparam int MW_TA_BIT   = 2;
    localparam int MW_LAST_BIT = 0;

    // Idle filler: every strobe negated, end flag set
    localparam logic [WORD_W-1:0] IDLE_WORD = 32'hFF03_0001;

    typedef struct packed {
        logic [3:0] cs_n;
        logic [3:0] we_n;
        logic [1:0] oe_n;
        logic       waen;
        logic [1:0] rep;
        logic       loop_m;
        logic       ta;
        logic       last;
    } uword_t;

    function automatic uword_t decode_word(input logic [WORD_W-1:0] w);
        uword_t d;
        d.cs_n   = w[MW_CS_LSB +: 4];
        d.we_n   = w[MW_WE_LSB +: 4];
        d.oe_n   = w[MW_OE_LSB +: 2];
        d.waen   = w[MW_WAEN_BIT];
        d.rep    = w[MW_REP_LSB +: 2];
        d.loop_m = w[MW_LOOP_BIT];
        d.ta     = w[MW_TA_BIT];
        d.last   = w[MW_LAST_BIT];
        return d;
    endfunction

endpackage

// File: rtl/lbseq_regs.sv
// Host-visible mode and data registers.
// Assumes one register write per clock; a mode write takes priority over
// the address auto-increment, and a data write over a store fetch.
module lbseq_regs
    import lbseq_pkg::*;
#(
    parameter int AW = 6,
    parameter int LW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              addr_step,
    input  logic              data_load,
    input  logic [WORD_W-1:0] data_in,
    output op_e               op,
    output logic [LW-1:0]     rd_loop,
    output logic [LW-1:0]     wr_loop,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] rdata
);

    logic [1:0]        op_q;
    logic [WORD_W-1:0] mode_img;
    logic              mode_wr;
    logic              unused_wbits;

    assign mode_wr = reg_wr && !reg_sel;

    // Mode register: host write or address step after a store access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= 2'b00;
            rd_loop <= '0;
            wr_loop <= '0;
            addr    <= '0;
        end else if (mode_wr) begin
            op_q    <= reg_wdata[MODE_OP_LSB +: 2];
            rd_loop <= reg_wdata[MODE_RL_LSB +: LW];
            wr_loop <= reg_wdata[MODE_WL_LSB +: LW];
            addr    <= reg_wdata[MODE_AD_LSB +: AW];
        end else if (addr_step) begin
            addr <= addr + AW'(1);
        end
    end

    // Data register: host write or word fetched from the store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (reg_wr && reg_sel) begin
            data <= reg_wdata;
        end else if (data_load) begin
            data <= data_in;
        end
    end

    // Read-back image of the mode register, undefined bits zero
    always_comb begin
        mode_img = '0;
        mode_img[MODE_OP_LSB +: 2]  = op_q;
        mode_img[MODE_RL_LSB +: LW] = rd_loop;
        mode_img[MODE_WL_LSB +: LW] = wr_loop;
        mode_img[MODE_AD_LSB +: AW] = addr;
    end

    assign op           = op_e'(op_q);
    assign rdata        = reg_sel ? data : mode_img;
    assign unused_wbits = ^{reg_wdata[31:30], reg_wdata[27:18], reg_wdata[9:AW]};

endmodule

// File: rtl/lbseq_ram.sv
// Pattern store: one write port, three asynchronous read ports.
// Assumes reset loads every entry with the idle filler word.
module lbseq_ram
    import lbseq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     ra_a,
    input  logic [AW-1:0]     ra_b,
    input  logic [AW-1:0]     ra_c,
    output logic [WORD_W-1:0] rd_a,
    output logic [WORD_W-1:0] rd_b,
    output logic [WORD_W-1:0] rd_c
);

    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Entry i: filler on reset, host data on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= IDLE_WORD;
            end else if (we && waddr == AW'(i)) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    assign rd_c = mem[ra_c];

endmodule

// File: rtl/lbseq_engine.sv
// Pattern player: steps through microwords, honours hold counts, wait
// stalls and one loop body, and ends on the word carrying the end flag.
// Assumes cur is the decoded word at pc and nxt_loop is the loop bit of
// the word at pc+1; start is ignored while a pattern plays.
module lbseq_engine
    import lbseq_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LW     = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [AW-1:0]     start_pc,
    input  logic [LW-1:0]     loop_cfg,
    input  uword_t            cur,
    input  logic              nxt_loop,
    input  logic              ext_wait,
    input  logic [DATA_W-1:0] ext_din,
    output logic              active,
    output logic [AW-1:0]     pc,
    output logic [1:0]        rep_cnt,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        cs_q_n,
    output logic [3:0]        we_q_n,
    output logic [1:0]        oe_h_n,
    output logic              ta
);

    localparam int LCW = LW + 1;
    localparam logic [LCW-1:0] LOOP_MAX = LCW'(1 << LW);

    logic [LCW-1:0] loop_left;
    logic [AW-1:0]  loop_head;
    logic           rd_q;
    logic           stall;
    logic           word_end;
    logic           body_end;
    logic [AW-1:0]  pc_inc;
    logic [LCW-1:0] loop_init;

    assign stall     = cur.waen && ext_wait;
    assign word_end  = active && !stall && (rep_cnt == cur.rep);
    assign body_end  = cur.loop_m && !nxt_loop;
    assign pc_inc    = pc + AW'(1);
    assign loop_init = (loop_cfg == '0) ? LOOP_MAX : {1'b0, loop_cfg};

    // Sequencing state: start, hold count, loop jump, advance, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            pc        <= '0;
            rep_cnt   <= '0;
            loop_left <= '0;
            loop_head <= '0;
            rd_q      <= 1'b0;
        end else if (!active) begin
            if (start) begin
                active    <= 1'b1;
                pc        <= start_pc;
                rep_cnt   <= '0;
                loop_left <= loop_init;
                loop_head <= start_pc;
                rd_q      <= start_rd;
            end
        end else if (!stall) begin
            if (rep_cnt != cur.rep) begin
                rep_cnt <= rep_cnt + 2'd1;
            end else begin
                rep_cnt <= '0;
                if (cur.last) begin
                    active <= 1'b0;
                end else if (body_end && loop_left > LCW'(1)) begin
                    loop_left <= loop_left - LCW'(1);
                    pc        <= loop_head;
                end else begin
                    pc <= pc_inc;
                    if (nxt_loop && !cur.loop_m) begin
                        loop_head <= pc_inc;
                    end
                end
            end
        end
    end

    // Completion pulse and read-data capture on the final clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= word_end && cur.last;
            if (word_end && cur.last && rd_q) begin
                rd_data <= ext_din;
            end
        end
    end

    // Strobe drive: current word while playing, negated when idle
    always_comb begin
        if (active) begin
            cs_q_n = cur.cs_n;
            we_q_n = cur.we_n;
            oe_h_n = cur.oe_n;
            ta     = cur.ta;
        end else begin
            cs_q_n = 4'hF;
            we_q_n = 4'hF;
            oe_h_n = 2'b11;
            ta     = 1'b0;
        end
    end

endmodule

// File: rtl/lbus_microseq.sv
// Top of the microcoded local-bus sequencer: registers, pattern store,
// and pattern player, plus the request decode that ties them together.
// Assumes the host leaves the operation unchanged while a pattern plays.
module lbus_microseq
    import lbseq_pkg::*;
#(
    parameter int AW      = 6,
    parameter int LW      = 4,
    parameter int DATA_W  = 32,
    parameter int RD_BASE = 0,
    parameter int WR_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dev_req,
    input  logic              dev_we,
    input  logic              ext_wait,
    input  logic [DATA_W-1:0] ext_din,
    output logic [3:0]        cs_q_n,
    output logic [3:0]        we_q_n,
    output logic [1:0]        oe_h_n,
    output logic              ta,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    op_e               op_q;
    logic [LW-1:0]     rd_loop;
    logic [LW-1:0]     wr_loop;
    logic [AW-1:0]     addr_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] word_a;
    logic [WORD_W-1:0] word_b;
    logic [WORD_W-1:0] word_c;
    uword_t            cur_word;
    logic              eng_active;
    logic [AW-1:0]     eng_pc;
    logic [1:0]        eng_rep;
    logic              store_wr;
    logic              store_rd;
    logic              seq_start;
    logic [AW-1:0]     seq_pc;
    logic [LW-1:0]     seq_loop;
    logic              unused_wordb;

    // Request decode per operation
    assign store_wr  = dev_req && (op_q == OP_LOAD);
    assign store_rd  = dev_req && (op_q == OP_FETCH);
    assign seq_start = dev_req && !eng_active && (op_q == OP_NORMAL || op_q == OP_RUN);
    assign seq_pc    = (op_q == OP_RUN) ? addr_q
                     : (dev_we ? AW'(WR_BASE) : AW'(RD_BASE));
    assign seq_loop  = dev_we ? wr_loop : rd_loop;
    assign cur_word  = decode_word(word_a);
    assign unused_wordb = ^{word_b[WORD_W-1:MW_LOOP_BIT+1], word_b[MW_LOOP_BIT-1:0]};

    lbseq_regs #(.AW(AW), .LW(LW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .addr_step (store_wr || store_rd),
        .data_load (store_rd),
        .data_in   (word_c),
        .op        (op_q),
        .rd_loop   (rd_loop),
        .wr_loop   (wr_loop),
        .addr      (addr_q),
        .data      (data_q),
        .rdata     (reg_rdata)
    );

    lbseq_ram #(.AW(AW)) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_wr),
        .waddr (addr_q),
        .wdata (data_q),
        .ra_a  (eng_pc),
        .ra_b  (eng_pc + AW'(1)),
        .ra_c  (addr_q),
        .rd_a  (word_a),
        .rd_b  (word_b),
        .rd_c  (word_c)
    );

    lbseq_engine #(.AW(AW), .LW(LW), .DATA_W(DATA_W)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .start_rd (!dev_we),
        .start_pc (seq_pc),
        .loop_cfg (seq_loop),
        .cur      (cur_word),
        .nxt_loop (word_b[MW_LOOP_BIT]),
        .ext_wait (ext_wait),
        .ext_din  (ext_din),
        .active   (eng_active),
        .pc       (eng_pc),
        .rep_cnt  (eng_rep),
        .done     (done),
        .rd_data  (rd_data),
        .cs_q_n   (cs_q_n),
        .we_q_n   (we_q_n),
        .oe_h_n   (oe_h_n),
        .ta       (ta)
    );

endmodule

// File: rtl/lbseq_chk.sv
// Protocol checker for the sequencer, bound to the top module.
// Assumes the internal names op_q, addr_q, eng_active, eng_pc, eng_rep
// and cur_word exist in the top.
module lbseq_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    op,
    input logic [AW-1:0] addr,
    input logic          dev_req,
    input logic          reg_wr,
    input logic          reg_sel,
    input logic          active,
    input logic [AW-1:0] pc,
    input logic [1:0]    rep,
    input logic          waen,
    input logic          ext_wait,
    input logic          done,
    input logic [3:0]    cs_q_n,
    input logic [3:0]    we_q_n,
    input logic [1:0]    oe_h_n,
    input logic          ta
);

    assert_idle_negated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (cs_q_n == 4'hF && we_q_n == 4'hF && oe_h_n == 2'b11 && !ta));

    assert_load_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && dev_req && !(reg_wr && !reg_sel)) |=> addr == AW'($past(addr) + AW'(1)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);

    assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && waen && ext_wait) |=> (active && pc == $past(pc) && rep == $past(rep)));

    assert_run_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b11 && !(reg_wr && !reg_sel)) |=> addr == $past(addr));

endmodule

bind lbus_microseq lbseq_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op_q),
    .addr     (addr_q),
    .dev_req  (dev_req),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .active   (eng_active),
    .pc       (eng_pc),
    .rep      (eng_rep),
    .waen     (cur_word.waen),
    .ext_wait (ext_wait),
    .done     (done),
    .cs_q_n   (cs_q_n),
    .we_q_n   (we_q_n),
    .oe_h_n   (oe_h_n),
    .ta       (ta)
);

// File: tb/lbus_microseq_tb_top.sv
// Self-checking bench: store sweeps, loop-count sweep, wait, write, run
// and busy-request scenarios with arithmetic expectations.
module lbus_microseq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_req = 1'b0;
    logic        dev_we = 1'b0;
    logic        ext_wait = 1'b0;
    logic [31:0] ext_din = '0;
    logic [3:0]  cs_q_n;
    logic [3:0]  we_q_n;
    logic [1:0]  oe_h_n;
    logic        ta;
    logic        done;
    logic [31:0] rd_data;

    int errs = 0;
    int nchk = 0;
    bit finished = 0;

    logic [3:0] tr_cs [0:127];
    logic [3:0] tr_we [0:127];
    logic [1:0] tr_oe [0:127];
    logic       tr_ta [0:127];

    always #4 clk = ~clk;

    lbus_microseq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
        .dev_we(dev_we), .ext_wait(ext_wait), .ext_din(ext_din),
        .cs_q_n(cs_q_n), .we_q_n(we_q_n), .oe_h_n(oe_h_n), .ta(ta),
        .done(done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_mode(input int op, input int rl, input int wl, input int ad);
        return (32'(op) << 28) | (32'(rl) << 14) | (32'(wl) << 10) | 32'(ad);
    endfunction

    function automatic logic [31:0] mk_word(input int cs, input int we, input int oe, input int rep,
                                            input int lp, input int wen, input int tack, input int lst);
        return (32'(cs) << 28) | (32'(we) << 24) | (32'(oe) << 16) | (32'(wen) << 12) |
               (32'(rep) << 8) | (32'(lp) << 7) | (32'(tack) << 2) | 32'(lst);
    endfunction

    function automatic logic [31:0] sweep_val(input int i);
        return (32'(i) * 32'h0101_0101) ^ 32'h5A3C_0F00;
    endfunction

    task automatic wr_reg(input bit sel, input logic [31:0] v);
        @(negedge clk); reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input bit sel, output logic [31:0] v);
        @(negedge clk); reg_sel = sel; #1; v = reg_rdata;
    endtask

    task automatic store_access();
        @(negedge clk); dev_req = 1'b1;
        @(negedge clk); dev_req = 1'b0;
    endtask

    task automatic program_word(input logic [31:0] w);
        wr_reg(1'b1, w);
        store_access();
    endtask

    // Plays one request; len = clocks the pattern occupied before done
    task automatic run_req(input logic wr, input int wfrom, input int wlen,
                           input bit hold, output int len);
        int n;
        bit fin;
        @(negedge clk); dev_we = wr; dev_req = 1'b1;
        @(negedge clk); if (!hold) dev_req = 1'b0;
        n = 0; fin = 0;
        while (!fin && n < 120) begin
            ext_wait = (n >= wfrom && n < wfrom + wlen);
            ext_din  = 32'hD000_0000 + 32'(n);
            if (done) begin
                fin = 1;
            end else begin
                tr_cs[n] = cs_q_n; tr_we[n] = we_q_n; tr_oe[n] = oe_h_n; tr_ta[n] = ta;
                n++;
                @(negedge clk);
            end
        end
        dev_req = 1'b0; ext_wait = 1'b0;
        len = n;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errs++; nchk++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int len;
        int cnt;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        chk(cs_q_n == 4'hF && we_q_n == 4'hF && oe_h_n == 2'b11, "R1", "idle strobes",
            {cs_q_n, we_q_n, oe_h_n}, 10'h3FF);
        chk(!ta && !done && rd_data == 0, "R1", "ta/done/rd_data", {ta, done, rd_data}, 0);
        rd_reg(1'b0, v); chk(v == 0, "R1", "mode after reset", v, 0);
        rd_reg(1'b1, v); chk(v == 0, "R1", "data after reset", v, 0);

        // R2: register fields and reserved bits
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_reg(1'b0, v); chk(v == 32'h3003_FC3F, "R2", "mode all-ones", v, 32'h3003_FC3F);
        wr_reg(1'b0, mk_mode(0, 5, 9, 17));
        rd_reg(1'b0, v); chk(v == mk_mode(0, 5, 9, 17), "R2", "mode fields", v, mk_mode(0, 5, 9, 17));
        wr_reg(1'b1, 32'hCAFE_F00D);
        rd_reg(1'b1, v); chk(v == 32'hCAFE_F00D, "R2", "data reg", v, 32'hCAFE_F00D);

        // R5 / R4: reset filler via fetch, address wrap
        wr_reg(1'b0, mk_mode(2, 0, 0, 5));
        store_access();
        rd_reg(1'b1, v); chk(v == 32'hFF03_0001, "R5", "filler word 5", v, 32'hFF03_0001);
        rd_reg(1'b0, v); chk(v[5:0] == 6, "R4", "fetch addr step", v[5:0], 6);
        wr_reg(1'b0, mk_mode(2, 0, 0, 63));
        store_access();
        rd_reg(1'b1, v); chk(v == 32'hFF03_0001, "R5", "filler word 63", v, 32'hFF03_0001);
        rd_reg(1'b0, v); chk(v[5:0] == 0, "R4", "fetch addr wrap", v[5:0], 0);

        // R3: load sweep over the whole store with address checks
        wr_reg(1'b0, mk_mode(1, 0, 0, 0));
        for (int i = 0; i < 64; i++) begin
            program_word(sweep_val(i));
            rd_reg(1'b0, v);
            chk(v[5:0] == 6'((i + 1) % 64), "R3", "load addr step", v[5:0], (i + 1) % 64);
        end
        // R4: fetch sweep reads every word back
        wr_reg(1'b0, mk_mode(2, 0, 0, 0));
        for (int i = 0; i < 64; i++) begin
            store_access();
            rd_reg(1'b1, v);
            chk(v == sweep_val(i), "R4", "fetch sweep data", v, sweep_val(i));
        end

        // Program read pattern at 0 and write pattern at 24
        wr_reg(1'b0, mk_mode(1, 0, 0, 0));
        program_word(mk_word(1, 15, 3, 1, 0, 0, 0, 0));
        program_word(mk_word(2, 15, 2, 0, 1, 0, 0, 0));
        program_word(mk_word(3, 15, 0, 2, 1, 1, 0, 0));
        program_word(mk_word(4, 15, 3, 0, 0, 0, 1, 1));
        wr_reg(1'b0, mk_mode(1, 0, 0, 24));
        program_word(mk_word(5, 8, 3, 3, 0, 0, 0, 0));
        program_word(mk_word(6, 0, 3, 0, 0, 0, 1, 1));

        // R6/R7/R8: read pattern with loop count 1
        wr_reg(1'b0, mk_mode(0, 1, 0, 0));
        run_req(1'b0, 99, 0, 1'b0, len);
        chk(len == 7, "R7", "read length", len, 7);
        chk(tr_cs[0] == 1 && tr_cs[1] == 1 && tr_cs[2] == 2, "R6", "read order w0/w1",
            {tr_cs[0], tr_cs[1], tr_cs[2]}, 12'h112);
        chk(tr_cs[3] == 3 && tr_cs[5] == 3 && tr_cs[6] == 4, "R7", "read order w2/w3",
            {tr_cs[3], tr_cs[5], tr_cs[6]}, 12'h334);
        chk(tr_oe[2] == 2'b10 && tr_oe[3] == 2'b00, "R6", "oe halves", {tr_oe[2], tr_oe[3]}, 4'b1000);
        chk(tr_ta[6] && !tr_ta[5], "R6", "ta on last word", {tr_ta[6], tr_ta[5]}, 2'b10);
        chk(done && cs_q_n == 4'hF && oe_h_n == 2'b11, "R8", "done with idle strobes",
            {done, cs_q_n, oe_h_n}, 7'h7F);
        chk(rd_data == 32'hD000_0006, "R8", "read capture", rd_data, 32'hD000_0006);
        @(negedge clk);
        chk(!done, "R8", "done single pulse", done, 0);

        // R10: sweep every read loop count
        for (int rl = 0; rl < 16; rl++) begin
            wr_reg(1'b0, mk_mode(0, rl, 0, 0));
            run_req(1'b0, 99, 0, 1'b0, len);
            chk(len == 3 + 4 * ((rl == 0) ? 16 : rl), "R10", "loop length", len,
                3 + 4 * ((rl == 0) ? 16 : rl));
        end

        // R9: wait on wait-enabled word stalls; on others it does nothing
        wr_reg(1'b0, mk_mode(0, 1, 0, 0));
        run_req(1'b0, 3, 5, 1'b0, len);
        chk(len == 12, "R9", "wait stall length", len, 12);
        cnt = 0;
        for (int k = 0; k < len; k++) if (tr_cs[k] == 3) cnt++;
        chk(cnt == 8, "R9", "stalled word clocks", cnt, 8);
        run_req(1'b0, 0, 2, 1'b0, len);
        chk(len == 7, "R9", "wait ignored without enable", len, 7);

        // R6/R8/R10: write pattern at 24, write loop ignored by reads and vice versa
        wr_reg(1'b0, mk_mode(0, 3, 7, 0));
        run_req(1'b1, 99, 0, 1'b0, len);
        chk(len == 5, "R7", "write length", len, 5);
        chk(tr_cs[0] == 5 && tr_we[0] == 8 && tr_cs[4] == 6 && tr_we[4] == 0, "R6", "write start 24",
            {tr_cs[0], tr_we[0], tr_cs[4], tr_we[4]}, 16'h5860);
        chk(tr_ta[4] && !tr_ta[3], "R6", "write ta", {tr_ta[4], tr_ta[3]}, 2'b10);
        chk(rd_data == 32'hD000_0006, "R8", "write leaves rd_data", rd_data, 32'hD000_0006);

        // R11: run mode from address field, address unchanged
        wr_reg(1'b0, mk_mode(3, 1, 0, 25));
        run_req(1'b0, 99, 0, 1'b0, len);
        chk(len == 1 && tr_cs[0] == 6, "R11", "run from addr 25", {len[7:0], tr_cs[0]}, 12'h016);
        rd_reg(1'b0, v); chk(v[5:0] == 25, "R11", "run addr held", v[5:0], 25);
        wr_reg(1'b0, mk_mode(3, 2, 0, 0));
        run_req(1'b0, 99, 0, 1'b0, len);
        chk(len == 11, "R11", "run from addr 0", len, 11);

        // R12: request held high during a pattern is ignored
        wr_reg(1'b0, mk_mode(0, 2, 0, 0));
        run_req(1'b0, 99, 0, 1'b1, len);
        chk(len == 11, "R12", "busy request length", len, 11);
        @(negedge clk);
        chk(cs_q_n == 4'hF && !done, "R12", "no restart", {cs_q_n, done}, 5'h1E);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

endmodule